// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a number of seconds that software loads into it, and raises an event when that count expires. A 1 Hz tick pulse, synchronous to the register clock, advances the countdown by one while the run control is set. When the count steps from one to zero a sticky pending flag is set and the counter rests at zero until it is reloaded.

The pending flag feeds two outputs, an interrupt request and a wakeup request, each gated by its own enable bit. Software clears the flag by writing a one to it. Before arming a new alarm, software typically writes zero to the counter, waits, and then writes the new count. A load therefore always replaces the running value outright, and any tick that lands in the same cycle is discarded.

The register port is a single-cycle write strobe with a word address and a combinational read-back of the addressed word. Word addresses: 0 = count load (reads back the last loaded value), 1 = remaining count (read only), 2 = run control, 3 = interrupt enable, 4 = status, 5 = wakeup enable. Bit 0 is the only meaningful bit of words 2 to 5. Other addresses read as zero.

Top module: `sec_alarm`

## Requirements
- R1: After reset, every register word (addresses 0 to 5) reads zero, and irq_o and wake_o are low.
- R2: A write to address 0 sets the remaining count (address 1) and the load read-back (address 0) to the written 32-bit value, visible in the cycle after the write.
- R3: The remaining count drops by exactly one on each cycle with tick_i high while run (address 2, bit 0) is 1 and the count is non-zero. It does not change without a tick or while run is 0.
- R4: On the tick at which the count goes from 1 to 0, the pending flag (address 4, bit 0) becomes 1. The count then stays at 0 under further ticks until a new load.
- R5: Loading 0 never sets the pending flag, however many ticks follow with run set.
- R6: Writing address 4 with bit 0 = 1 clears the pending flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: irq_o is high exactly when the pending flag is 1 and the interrupt enable (address 3, bit 0) is 1.
- R8: wake_o is high exactly when the pending flag is 1 and the wakeup enable (address 5, bit 0) is 1.
- R9: A load in the same cycle as a counting tick takes the loaded value with no decrement. A load while the counter is running restarts the countdown from the new value.
- R10: If the expiry tick and a status clear fall in the same cycle, the pending flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 1 Hz tick pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The countdown is tried with ticks while run is off, with widely spaced ticks and with back-to-back ticks, which separates counting on ticks from counting on clocks and from ignoring the run control. Expiry is driven with the enables off and then on, so the flag is told apart from its two gated outputs, and extra ticks after expiry show whether the counter wraps. A zero load, a reload in mid-count, a reload coinciding with a tick, and a clear coinciding with expiry expose the priority choices between load, decrement, set and clear.

// File: rtl/sec_alarm_pkg.sv
`timescale 1ns/1ps
package sec_alarm_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOAD   = 3'd0,
        REG_REMAIN = 3'd1,
        REG_RUN    = 3'd2,
        REG_IRQEN  = 3'd3,
        REG_STATUS = 3'd4,
        REG_WAKE   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic irq_en;
        logic wake_en;
    } ctrl_t;

    function automatic logic hit(input logic wr, input logic [ADDR_W-1:0] addr,
                                 input reg_sel_e sel);
        return wr && (addr == sel);
    endfunction

endpackage

// File: rtl/sa_regfile.sv
`timescale 1ns/1ps
module sa_regfile
    import sec_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              load_stb_o,
    output logic              clr_stb_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] load_q;

    assign load_stb_o = hit(wr_i, addr_i, REG_LOAD);
    assign clr_stb_o  = hit(wr_i, addr_i, REG_STATUS) && wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (load_stb_o)                      load_q         <= wdata_i;
            if (hit(wr_i, addr_i, REG_RUN))      ctrl_q.run     <= wdata_i[0];
            if (hit(wr_i, addr_i, REG_IRQEN))    ctrl_q.irq_en  <= wdata_i[0];
            if (hit(wr_i, addr_i, REG_WAKE))     ctrl_q.wake_en <= wdata_i[0];
        end
    end

    assign ctrl_o     = ctrl_q;
    assign load_val_o = load_q;

    // R2
    load_keep_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb_o |=> load_val_o == $past(wdata_i));

endmodule

// File: rtl/sa_counter.sv
`timescale 1ns/1ps
module sa_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_stb_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step     = run_i && tick_i && !load_stb_i && (cnt_q != '0);
    assign expire_o = step && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (load_stb_i) cnt_q <= load_val_i;
        else if (step)       cnt_q <= cnt_q - ONE;
    end

    assign cnt_o = cnt_q;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && !load_stb_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - ONE);

    // R3
    count_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_stb_i && !(run_i && tick_i)) |=> $stable(cnt_o));

    // R4
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_stb_i && cnt_o == '0) |=> cnt_o == '0);

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb_i |=> cnt_o == $past(load_val_i));

endmodule

// File: rtl/sa_pending.sv
`timescale 1ns/1ps
module sa_pending (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)        pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    // R4 R10
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> pend_o);

    // R6
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !pend_o);

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && pend_o) |=> pend_o);

endmodule

// File: rtl/sec_alarm.sv
`timescale 1ns/1ps
module sec_alarm
    import sec_alarm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic             load_stb;
    logic             clr_stb;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             pend;

    sa_regfile #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .ctrl_o     (ctrl),
        .load_val_o (load_val),
        .load_stb_o (load_stb),
        .clr_stb_o  (clr_stb)
    );

    sa_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .run_i      (ctrl.run),
        .load_stb_i (load_stb),
        .load_val_i (wdata_i),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    sa_pending pend_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (expire),
        .clr_i  (clr_stb),
        .pend_o (pend)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_LOAD:   rdata_o = load_val;
            REG_REMAIN: rdata_o = cnt;
            REG_RUN:    rdata_o[0] = ctrl.run;
            REG_IRQEN:  rdata_o[0] = ctrl.irq_en;
            REG_STATUS: rdata_o[0] = pend;
            REG_WAKE:   rdata_o[0] = ctrl.wake_en;
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o  = pend & ctrl.irq_en;
    assign wake_o = pend & ctrl.wake_en;

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ctrl.irq_en && pend));

    // R8
    wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (ctrl.wake_en && pend));

    // R5
    zero_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_stb && wdata_i == '0) |=> !expire);

endmodule

// File: tb/sec_alarm_tb_top.sv
`timescale 1ns/1ps
module sec_alarm_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;
    logic        wake;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // reference model state
    logic [31:0] m_load, m_cnt;
    bit          m_run, m_ien, m_wen, m_pend;

    always #5 clk = ~clk;

    sec_alarm dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_load <= 0; m_cnt <= 0; m_run <= 0; m_ien <= 0; m_wen <= 0; m_pend <= 0;
        end else begin
            bit do_load, do_step, do_set, do_clr;
            do_load = wr && addr == 3'd0;
            do_step = !do_load && m_run && tick && m_cnt != 0;
            do_set  = do_step && m_cnt == 1;
            do_clr  = wr && addr == 3'd4 && wdata[0];
            if (do_load) begin m_load <= wdata; m_cnt <= wdata; end
            else if (do_step) m_cnt <= m_cnt - 1;
            if (wr && addr == 3'd2) m_run <= wdata[0];
            if (wr && addr == 3'd3) m_ien <= wdata[0];
            if (wr && addr == 3'd5) m_wen <= wdata[0];
            if (do_set) m_pend <= 1;
            else if (do_clr) m_pend <= 0;
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_load;
            3'd1: return m_cnt;
            3'd2: return {31'd0, m_run};
            3'd3: return {31'd0, m_ien};
            3'd4: return {31'd0, m_pend};
            3'd5: return {31'd0, m_wen};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(cur_req, "rdata", rdata, model_read(addr));
            check("R7", "irq_o", {31'd0, irq}, {31'd0, m_pend && m_ien});
            check("R8", "wake_o", {31'd0, wake}, {31'd0, m_pend && m_wen});
        end
    end

    task automatic cyc(input bit t, input bit w, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        tick = t; wr = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd1, 0);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        cyc(0, 0, a, 0);
        @(negedge clk);
        check(req, "directed read", rdata, exp);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 3'd1, 0);
            idle(gap);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        for (int a = 0; a < 6; a++) rd(3'(a), 32'd0, "R1");
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);
        check("R1", "wake after reset", {31'd0, wake}, 32'd0);

        // R2 load
        cur_req = "R2";
        cyc(0, 1, 3'd0, 32'd5);
        rd(3'd1, 32'd5, "R2");
        rd(3'd0, 32'd5, "R2");

        // R3 no counting while run is off
        cur_req = "R3";
        ticks(3, 1);
        rd(3'd1, 32'd5, "R3");
        cyc(0, 1, 3'd2, 32'd1);
        ticks(1, 4);
        ticks(2, 0);
        rd(3'd1, 32'd2, "R3");

        // R4 expiry with enables off, then hold at zero
        cur_req = "R4";
        ticks(2, 1);
        rd(3'd4, 32'd1, "R4");
        check("R7", "irq masked", {31'd0, irq}, 32'd0);
        ticks(3, 0);
        rd(3'd1, 32'd0, "R4");

        // R7 / R8 gating
        cur_req = "R7";
        cyc(0, 1, 3'd3, 32'd1);
        idle(1);
        check("R7", "irq enabled", {31'd0, irq}, 32'd1);
        cur_req = "R8";
        cyc(0, 1, 3'd5, 32'd1);
        idle(1);
        check("R8", "wake enabled", {31'd0, wake}, 32'd1);
        cyc(0, 1, 3'd3, 32'd0);
        idle(1);
        check("R7", "irq disabled", {31'd0, irq}, 32'd0);
        check("R8", "wake still on", {31'd0, wake}, 32'd1);

        // R6 write-one-to-clear
        cur_req = "R6";
        cyc(0, 1, 3'd4, 32'hFFFF_FFFE);
        rd(3'd4, 32'd1, "R6");
        cyc(0, 1, 3'd4, 32'd1);
        rd(3'd4, 32'd0, "R6");
        check("R8", "wake after clear", {31'd0, wake}, 32'd0);

        // R5 zero load
        cur_req = "R5";
        cyc(0, 1, 3'd0, 32'd0);
        ticks(4, 1);
        rd(3'd4, 32'd0, "R5");

        // R9 reload mid-count and load coinciding with tick
        cur_req = "R9";
        cyc(0, 1, 3'd0, 32'd10);
        ticks(2, 1);
        rd(3'd1, 32'd8, "R9");
        cyc(1, 1, 3'd0, 32'd3);
        rd(3'd1, 32'd3, "R9");
        ticks(1, 0);
        rd(3'd1, 32'd2, "R9");
        cyc(0, 1, 3'd0, 32'hFFFF_FFFF);
        ticks(1, 0);
        rd(3'd1, 32'hFFFF_FFFE, "R9");

        // R10 expiry and clear in the same cycle
        cur_req = "R10";
        cyc(0, 1, 3'd0, 32'd1);
        cyc(1, 1, 3'd4, 32'd1);
        rd(3'd4, 32'd1, "R10");
        rd(3'd1, 32'd0, "R10");

        idle(2);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule